// File: doc/BRIEF.md
# Reconfigurable 8-bit Datapath

This block is a small byte-wide datapath for simple embedded jobs such as counting, timing, pulse generation or checksum steps. It holds two accumulators, two data registers, a mask register, an inbound FIFO and an outbound FIFO, along with a single-cycle ALU followed by a shift stage and a mask stage. It does not decode instructions. A 3-bit select input picks one of eight stored 16-bit configuration words on every clock. That word sets the ALU function, the two operand sources, the shift, the mask and where the result goes. Changing the select from one cycle to the next changes what the datapath does on that cycle.

A host loads the configuration words and the registers through a simple write port and reads them back through a combinational read port. The host feeds the inbound FIFO (F0) and drains the outbound FIFO (F1). Both FIFOs report full and empty flags. A push into a full FIFO or a pop from an empty FIFO is dropped and sets a sticky error bit. Two compare outputs report accumulator and data register equality, and a zero flag reports whether the last ALU result was zero.

Top module: `dyn_datapath`

## Requirements
- R1: The word at configuration address `cfg_sel` controls the cycle in which it is selected. A host write to configuration address k (host addresses 0 to 7, all 16 bits) takes effect from the cycle after the write. A cycle that selects k while k is being written uses the old word. After reset all eight words are zero, and word zero causes no register or FIFO change.
- R2: Configuration bits [2:0] select the ALU function on operands A and B: 0 pass B, 1 A+1, 2 A-1, 3 A+B, 4 A-B, 5 A AND B, 6 A OR B, 7 A XOR B. All arithmetic wraps modulo 256.
- R3: Bits [8:7] set the shift applied to the ALU output: 0 none, 1 left by one with zero fill, 2 right by one with zero fill, 3 swap the two nibbles.
- R4: When bit 12 is set, the shifted value is ANDed with the mask register. The mask register is at host address 12 and resets to 0xFF.
- R5: Bit 9 writes the final result into A0 and bit 10 writes it into A1. A host write to the same accumulator in the same cycle wins. D0 and D1 change only through host writes. Host addresses are A0=8, A1=9, D0=10, D1=11, and reads return the register zero-extended.
- R6: Bits [4:3] select operand A as 0 A0, 1 A1, 2 D0, 3 D1. Bits [6:5] select operand B as 0 D0, 1 D1, 2 A1, 3 head of F0. Selecting code 3 pops F0, and if F0 is empty the operand is 0.
- R7: Bit 11 pushes the final result into F1. A host write to address 13 pushes into F0. A host read of address 13 returns the head of F1, or 0 when F1 is empty, and asserting `host_re` there pops F1.
- R8: Each FIFO holds 4 bytes in first-in first-out order and drives full and empty flags. A push and a pop in the same cycle both take effect when the FIFO is not empty, even when it is full.
- R9: A dropped push (full, no pop) or a dropped pop (empty) leaves the FIFO unchanged and sets a sticky bit at host address 14: bit0 F0 overflow, bit1 F0 underflow, bit2 F1 overflow, bit3 F1 underflow. Writing 1 to a bit at address 14 clears it, and a new event in the same cycle wins.
- R10: `cmp_eq0` is high whenever A0 equals D0, and `cmp_eq1` is high whenever A1 equals D1, with no added cycle of delay.
- R11: `zero_flag` is a register that, one cycle after each executed cycle, shows whether that cycle's final result was zero.
- R12: Reset is synchronous and active low. It clears the registers and FIFOs, clears the error bits and the zero flag, and sets the mask to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sel | input | 3 | Configuration word select for this cycle |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe (pops F1 at address 13) |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, combinational |
| cmp_eq0 | output | 1 | A0 equals D0 |
| cmp_eq1 | output | 1 | A1 equals D1 |
| zero_flag | output | 1 | Last result was zero |
| f0_full | output | 1 | Inbound FIFO full |
| f0_empty | output | 1 | Inbound FIFO empty |
| f1_full | output | 1 | Outbound FIFO full |
| f1_empty | output | 1 | Outbound FIFO empty |

## Verification
The host and the configured datapath can act on the same storage in the same cycle. The bench makes both cases happen. In the first, the host pushes into a full F0 in the same cycle that the active word pops F0. It then checks that neither side is refused, that no overflow bit appears, and that the new byte comes out last when F0 drains into F1. In the second, the active word increments A1 in the same cycle that the host writes A1, and the bench checks that the host value is what remains.

// File: rtl/dp_pkg.sv
// Package: shared types for the reconfigurable datapath.
// Assumes an 8-word configuration store of 16-bit words whose layout is the
// packed struct below (LSB first: function, source A, source B, shift, ...).
package dp_pkg;

    typedef enum logic [2:0] {
        FN_PASS = 3'd0,
        FN_INC  = 3'd1,
        FN_DEC  = 3'd2,
        FN_ADD  = 3'd3,
        FN_SUB  = 3'd4,
        FN_AND  = 3'd5,
        FN_OR   = 3'd6,
        FN_XOR  = 3'd7
    } alu_fn_e;

    typedef enum logic [1:0] {
        SH_NONE  = 2'd0,
        SH_LEFT  = 2'd1,
        SH_RIGHT = 2'd2,
        SH_SWAP  = 2'd3
    } shift_e;

    // Operand B source code that pops the inbound FIFO.
    localparam logic [1:0] SRCB_FIFO = 2'd3;

    typedef struct packed {
        logic [2:0] rsvd;
        logic       mask_en;
        logic       f1_push;
        logic       a1_we;
        logic       a0_we;
        shift_e     shift;
        logic [1:0] src_b;
        logic [1:0] src_a;
        alu_fn_e    fn;
    } cfg_word_t;

endpackage

// File: rtl/dp_cfg_ram.sv
// Module: configuration word store.
// Holds 2**AW words of CW bits. One combinational read port is driven by the
// per-cycle select and a second by the host. Writes land at the clock edge, so
// a word is used from the cycle after its write. Assumes synchronous active-low reset.
module dp_cfg_ram #(
    parameter int AW = 3,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [CW-1:0] wdata,
    input  logic [AW-1:0] sel,
    output logic [CW-1:0] sel_word,
    input  logic [AW-1:0] host_raddr,
    output logic [CW-1:0] host_word
);
    localparam int WORDS = 1 << AW;

    logic [CW-1:0] mem_q [WORDS];

    // Clear every word on reset, otherwise accept host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Per-cycle active word and host readback.
    assign sel_word  = mem_q[sel];
    assign host_word = mem_q[host_raddr];

endmodule

// File: rtl/dp_alu.sv
// Module: single-cycle ALU with a shift stage and a mask stage.
// Purely combinational. Arithmetic wraps modulo 2**DW. DW must be even so the
// nibble-swap shift can exchange the two halves.
module dp_alu
    import dp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  alu_fn_e       fn,
    input  shift_e        shift,
    input  logic          mask_en,
    input  logic [DW-1:0] mask,
    output logic [DW-1:0] result
);
    localparam int HW = DW / 2;

    logic [DW-1:0] raw;
    logic [DW-1:0] shifted;

    // Function stage.
    always_comb begin
        unique case (fn)
            FN_PASS: raw = op_b;
            FN_INC:  raw = op_a + DW'(1);
            FN_DEC:  raw = op_a - DW'(1);
            FN_ADD:  raw = op_a + op_b;
            FN_SUB:  raw = op_a - op_b;
            FN_AND:  raw = op_a & op_b;
            FN_OR:   raw = op_a | op_b;
            default: raw = op_a ^ op_b;
        endcase
    end

    // Shift stage.
    always_comb begin
        unique case (shift)
            SH_NONE:  shifted = raw;
            SH_LEFT:  shifted = {raw[DW-2:0], 1'b0};
            SH_RIGHT: shifted = {1'b0, raw[DW-1:1]};
            default:  shifted = {raw[HW-1:0], raw[DW-1:HW]};
        endcase
    end

    // Mask stage.
    assign result = mask_en ? (shifted & mask) : shifted;

endmodule

// File: rtl/dp_fifo.sv
// Module: small synchronous FIFO with full/empty flags and drop events.
// A pop succeeds when the FIFO is not empty. A push succeeds when the FIFO is
// not full, or when a pop succeeds in the same cycle. Refused requests leave the
// state unchanged and pulse ovf/unf. Assumes DEPTH >= 2.
module dp_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          full,
    output logic          empty,
    output logic          ovf,
    output logic          unf
);
    localparam int PW = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    logic [DW-1:0]   mem_q [DEPTH];
    logic [PW-1:0]   wr_q, rd_q;
    logic [CNTW-1:0] cnt_q;
    logic            push_ok, pop_ok;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == FULL_CNT);
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign ovf     = push && !push_ok;
    assign unf     = pop && !pop_ok;
    assign head    = mem_q[rd_q];

    // Pointer, count and storage update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (push_ok) begin
                mem_q[wr_q] <= wdata;
                wr_q <= (wr_q == LAST_PTR) ? '0 : wr_q + 1'b1;
            end
            if (pop_ok) begin
                rd_q <= (rd_q == LAST_PTR) ? '0 : rd_q + 1'b1;
            end
            cnt_q <= cnt_q + CNTW'(push_ok) - CNTW'(pop_ok);
        end
    end

    // R8: the flags are never both set.
    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R9: a refused push leaves a full FIFO full and its head unchanged.
    a_r9_push_full_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(head)));

    // R9: a refused pop leaves an empty FIFO empty.
    a_r9_pop_empty_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/dyn_datapath.sv
// Module: top of the reconfigurable datapath.
// Each cycle the word picked by cfg_sel drives operand selection, the ALU,
// the shift and mask stages, the accumulator write enables and the F1 push.
// The host owns D0/D1, the mask, the configuration words, F0 pushes and F1 pops.
// Host address map: configuration words in the lower half, registers above.
// Assumes CFG_AW >= 3 so that the seven register slots fit in the upper half.
module dyn_datapath
    import dp_pkg::*;
#(
    parameter int DW         = 8,
    parameter int CFG_AW     = 3,
    parameter int FIFO_DEPTH = 4,
    parameter int HDW        = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CFG_AW-1:0] cfg_sel,
    input  logic            host_we,
    input  logic            host_re,
    input  logic [CFG_AW:0] host_addr,
    input  logic [HDW-1:0]  host_wdata,
    output logic [HDW-1:0]  host_rdata,
    output logic            cmp_eq0,
    output logic            cmp_eq1,
    output logic            zero_flag,
    output logic            f0_full,
    output logic            f0_empty,
    output logic            f1_full,
    output logic            f1_empty
);
    localparam int HAW    = CFG_AW + 1;
    localparam int CW     = $bits(cfg_word_t);
    localparam int NERR   = 4;
    localparam int CFG_N  = 1 << CFG_AW;
    localparam logic [HAW-1:0] ADDR_A0   = HAW'(CFG_N + 0);
    localparam logic [HAW-1:0] ADDR_A1   = HAW'(CFG_N + 1);
    localparam logic [HAW-1:0] ADDR_D0   = HAW'(CFG_N + 2);
    localparam logic [HAW-1:0] ADDR_D1   = HAW'(CFG_N + 3);
    localparam logic [HAW-1:0] ADDR_MASK = HAW'(CFG_N + 4);
    localparam logic [HAW-1:0] ADDR_FIFO = HAW'(CFG_N + 5);
    localparam logic [HAW-1:0] ADDR_STAT = HAW'(CFG_N + 6);

    cfg_word_t       cfg;
    logic [CW-1:0]   cfg_raw, host_cfg_word;
    logic            cfg_region;
    logic [DW-1:0]   a0_q, a1_q, d0_q, d1_q, mask_q;
    logic [DW-1:0]   op_a, op_b, alu_res;
    logic            zero_q;
    logic [NERR-1:0] err_q, err_evt, err_clr;
    logic            f0_push, f0_pop, f1_push, f1_pop;
    logic [DW-1:0]   f0_head, f1_head;
    logic            f0_ovf, f0_unf, f1_ovf, f1_unf;
    logic            unused_rsvd;

    assign cfg_region  = !host_addr[HAW-1];
    assign cfg         = cfg_word_t'(cfg_raw);
    assign unused_rsvd = ^cfg.rsvd;

    dp_cfg_ram #(.AW(CFG_AW), .CW(CW)) i_cfg_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (host_we && cfg_region),
        .waddr      (host_addr[CFG_AW-1:0]),
        .wdata      (host_wdata[CW-1:0]),
        .sel        (cfg_sel),
        .sel_word   (cfg_raw),
        .host_raddr (host_addr[CFG_AW-1:0]),
        .host_word  (host_cfg_word)
    );

    // Operand A source selection.
    always_comb begin
        unique case (cfg.src_a)
            2'd0:    op_a = a0_q;
            2'd1:    op_a = a1_q;
            2'd2:    op_a = d0_q;
            default: op_a = d1_q;
        endcase
    end

    // Operand B source selection. The FIFO source reads 0 when F0 is empty.
    always_comb begin
        unique case (cfg.src_b)
            2'd0:    op_b = d0_q;
            2'd1:    op_b = d1_q;
            2'd2:    op_b = a1_q;
            default: op_b = f0_empty ? '0 : f0_head;
        endcase
    end

    dp_alu #(.DW(DW)) i_alu (
        .op_a    (op_a),
        .op_b    (op_b),
        .fn      (cfg.fn),
        .shift   (cfg.shift),
        .mask_en (cfg.mask_en),
        .mask    (mask_q),
        .result  (alu_res)
    );

    assign f0_push = host_we && (host_addr == ADDR_FIFO);
    assign f0_pop  = (cfg.src_b == SRCB_FIFO);
    assign f1_push = cfg.f1_push;
    assign f1_pop  = host_re && (host_addr == ADDR_FIFO);

    dp_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) i_fifo_in (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (f0_push),
        .wdata (host_wdata[DW-1:0]),
        .pop   (f0_pop),
        .head  (f0_head),
        .full  (f0_full),
        .empty (f0_empty),
        .ovf   (f0_ovf),
        .unf   (f0_unf)
    );

    dp_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) i_fifo_out (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (f1_push),
        .wdata (alu_res),
        .pop   (f1_pop),
        .head  (f1_head),
        .full  (f1_full),
        .empty (f1_empty),
        .ovf   (f1_ovf),
        .unf   (f1_unf)
    );

    // Accumulators: a host write has priority over the configured ALU write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a0_q <= '0;
            a1_q <= '0;
        end else begin
            if (host_we && host_addr == ADDR_A0)  a0_q <= host_wdata[DW-1:0];
            else if (cfg.a0_we)                   a0_q <= alu_res;
            if (host_we && host_addr == ADDR_A1)  a1_q <= host_wdata[DW-1:0];
            else if (cfg.a1_we)                   a1_q <= alu_res;
        end
    end

    // Data registers and mask: written by the host only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d0_q   <= '0;
            d1_q   <= '0;
            mask_q <= '1;
        end else if (host_we) begin
            if (host_addr == ADDR_D0)   d0_q   <= host_wdata[DW-1:0];
            if (host_addr == ADDR_D1)   d1_q   <= host_wdata[DW-1:0];
            if (host_addr == ADDR_MASK) mask_q <= host_wdata[DW-1:0];
        end
    end

    // Zero flag records the result of every executed cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) zero_q <= 1'b0;
        else        zero_q <= (alu_res == '0);
    end

    assign err_evt = {f1_unf, f1_ovf, f0_unf, f0_ovf};
    assign err_clr = (host_we && host_addr == ADDR_STAT) ? host_wdata[NERR-1:0] : '0;

    // Sticky error bits: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= (err_q & ~err_clr) | err_evt;
    end

    // Host read mux, combinational.
    always_comb begin
        host_rdata = '0;
        if (cfg_region) begin
            host_rdata = HDW'(host_cfg_word);
        end else begin
            unique case (host_addr)
                ADDR_A0:   host_rdata = HDW'(a0_q);
                ADDR_A1:   host_rdata = HDW'(a1_q);
                ADDR_D0:   host_rdata = HDW'(d0_q);
                ADDR_D1:   host_rdata = HDW'(d1_q);
                ADDR_MASK: host_rdata = HDW'(mask_q);
                ADDR_FIFO: host_rdata = f1_empty ? '0 : HDW'(f1_head);
                ADDR_STAT: host_rdata = HDW'(err_q);
                default:   host_rdata = '0;
            endcase
        end
    end

    assign cmp_eq0   = (a0_q == d0_q);
    assign cmp_eq1   = (a1_q == d1_q);
    assign zero_flag = zero_q;

    // R5: D0 and D1 hold their value unless the host writes them.
    a_r5_d0_host_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_we && host_addr == ADDR_D0) |=> $stable(d0_q));
    a_r5_d1_host_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_we && host_addr == ADDR_D1) |=> $stable(d1_q));

    // R5: a host write to A0 is kept even when the active word also writes A0.
    a_r5_host_wins_a0: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == ADDR_A0) |=> (a0_q == $past(host_wdata[DW-1:0])));

    // R9: error bits stay set until the host clears them.
    for (genvar gi = 0; gi < NERR; gi++) begin : g_err_chk
        a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (err_q[gi] && !err_clr[gi]) |=> err_q[gi]);
    end

endmodule

// File: tb/test_dyn_datapath.sv
// Bench: vector table for ALU, shift and mask, then directed tests.
module test_dyn_datapath;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic        host_we = 1'b0;
    logic        host_re = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        cmp_eq0, cmp_eq1, zero_flag;
    logic        f0_full, f0_empty, f1_full, f1_empty;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dyn_datapath i_dyn_datapath (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_sel    (cfg_sel),
        .host_we    (host_we),
        .host_re    (host_re),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .cmp_eq0    (cmp_eq0),
        .cmp_eq1    (cmp_eq1),
        .zero_flag  (zero_flag),
        .f0_full    (f0_full),
        .f0_empty   (f0_empty),
        .f1_full    (f1_full),
        .f1_empty   (f1_empty)
    );

    typedef struct packed {
        logic [2:0] fn;
        logic [1:0] sa;
        logic [1:0] sb;
        logic [1:0] sh;
        logic       mk;
        logic [7:0] a0;
        logic [7:0] a1;
        logic [7:0] d0;
        logic [7:0] d1;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd0, 2'd0, 2'd0, 1'b0, 8'h11, 8'h22, 8'h5A, 8'h77, 8'h5A},
        '{3'd1, 2'd1, 2'd0, 2'd0, 1'b0, 8'h11, 8'h22, 8'h5A, 8'h77, 8'h23},
        '{3'd2, 2'd0, 2'd0, 2'd0, 1'b0, 8'h00, 8'h22, 8'h5A, 8'h77, 8'hFF},
        '{3'd3, 2'd0, 2'd1, 2'd0, 1'b0, 8'hF0, 8'h22, 8'h5A, 8'h20, 8'h10},
        '{3'd4, 2'd2, 2'd2, 2'd0, 1'b0, 8'h00, 8'h30, 8'h10, 8'h77, 8'hE0},
        '{3'd5, 2'd3, 2'd0, 2'd0, 1'b0, 8'h00, 8'h22, 8'hAA, 8'hCC, 8'h88},
        '{3'd6, 2'd0, 2'd1, 2'd0, 1'b0, 8'h0F, 8'h22, 8'h5A, 8'h30, 8'h3F},
        '{3'd7, 2'd0, 2'd0, 2'd0, 1'b0, 8'hFF, 8'h22, 8'h0F, 8'h77, 8'hF0},
        '{3'd3, 2'd0, 2'd0, 2'd1, 1'b0, 8'h41, 8'h22, 8'h01, 8'h77, 8'h84},
        '{3'd0, 2'd0, 2'd0, 2'd2, 1'b0, 8'h00, 8'h22, 8'h81, 8'h77, 8'h40},
        '{3'd0, 2'd0, 2'd0, 2'd3, 1'b0, 8'h00, 8'h22, 8'hA5, 8'h77, 8'h5A},
        '{3'd6, 2'd0, 2'd0, 2'd0, 1'b1, 8'hF0, 8'h22, 8'h0C, 8'h77, 8'h0C},
        '{3'd7, 2'd0, 2'd0, 2'd3, 1'b1, 8'h12, 8'h22, 8'h34, 8'h77, 8'h02},
        '{3'd4, 2'd0, 2'd0, 2'd0, 1'b0, 8'h5A, 8'h22, 8'h5A, 8'h77, 8'h00}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [3:0] a, input logic [15:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic run(input logic [2:0] sel, input int n);
        cfg_sel = sel;
        repeat (n) @(negedge clk);
        cfg_sel = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        host_addr = a;
        #1;
        v = host_rdata;
    endtask

    task automatic pop1();
        host_re = 1'b1; host_addr = 4'd13;
        @(negedge clk);
        host_re = 1'b0;
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        vec_t        t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state.
        rd(4'd8, v);  chk("R12 A0 reset", v, 16'h0000);
        rd(4'd12, v); chk("R12 mask reset", v, 16'h00FF);
        rd(4'd14, v); chk("R12 status reset", v, 16'h0000);
        rd(4'd3, v);  chk("R12 R1 cfg word reset", v, 16'h0000);
        chk("R12 fifo flags", {12'h0, f0_full, f0_empty, f1_full, f1_empty}, 16'h0005);
        chk("R12 zero flag reset", {15'h0, zero_flag}, 16'h0000);

        // R2 R3 R4 R6 R11: vector walk, result written to A0 through word 1.
        hw(4'd12, 16'h000F);
        for (int i = 0; i < NV; i++) begin
            t = VECS[i];
            hw(4'd8, {8'h0, t.a0});
            hw(4'd9, {8'h0, t.a1});
            hw(4'd10, {8'h0, t.d0});
            hw(4'd11, {8'h0, t.d1});
            hw(4'd1, {3'b0, t.mk, 1'b0, 1'b0, 1'b1, t.sh, t.sb, t.sa, t.fn});
            run(3'd1, 1);
            rd(4'd8, v);
            chk($sformatf("R2 R3 R4 R6 vector %0d", i), v, {8'h0, t.exp});
            chk($sformatf("R11 zero vector %0d", i), {15'h0, zero_flag}, {15'h0, t.exp == 8'h00});
        end

        // R1: word written in the same cycle it is selected is not yet used.
        hw(4'd9, 16'h0040);
        host_we = 1'b1; host_addr = 4'd2; host_wdata = 16'h0409; cfg_sel = 3'd2;
        @(negedge clk);
        host_we = 1'b0;
        rd(4'd9, v); chk("R1 old word used in write cycle", v, 16'h0040);
        run(3'd2, 1);
        rd(4'd9, v); chk("R1 new word used next cycle", v, 16'h0041);

        // R5: host write to A1 wins over the active word's increment.
        host_we = 1'b1; host_addr = 4'd9; host_wdata = 16'h0070; cfg_sel = 3'd2;
        @(negedge clk);
        host_we = 1'b0; cfg_sel = '0;
        rd(4'd9, v);  chk("R5 host wins A1", v, 16'h0070);
        rd(4'd10, v); chk("R5 D0 untouched", v, 16'h005A);

        // R10: compare outputs.
        hw(4'd8, 16'h0033);
        hw(4'd10, 16'h0033);
        hw(4'd11, 16'h0034);
        chk("R10 eq0 high", {15'h0, cmp_eq0}, 16'h0001);
        chk("R10 eq1 low", {15'h0, cmp_eq1}, 16'h0000);
        hw(4'd11, 16'h0070);
        chk("R10 eq1 high", {15'h0, cmp_eq1}, 16'h0001);

        // R6 R7: F0 bytes pass through the ALU into A0 and F1.
        hw(4'd4, 16'h0A60);
        hw(4'd13, 16'h0001);
        hw(4'd13, 16'h0002);
        hw(4'd13, 16'h0003);
        run(3'd4, 3);
        rd(4'd8, v);  chk("R6 A0 from F0", v, 16'h0003);
        chk("R6 F0 drained", {15'h0, f0_empty}, 16'h0001);
        rd(4'd13, v); chk("R7 F1 head first", v, 16'h0001);
        pop1();
        rd(4'd13, v); chk("R7 F1 head second", v, 16'h0002);
        pop1();
        pop1();
        chk("R7 F1 empty", {15'h0, f1_empty}, 16'h0001);

        // R8 R9: fill F0, overflow, then push and pop together while full.
        hw(4'd13, 16'h0010);
        hw(4'd13, 16'h0011);
        hw(4'd13, 16'h0012);
        hw(4'd13, 16'h0013);
        chk("R8 F0 full", {15'h0, f0_full}, 16'h0001);
        hw(4'd13, 16'h0014);
        rd(4'd14, v); chk("R9 F0 overflow bit", v, 16'h0001);
        host_we = 1'b1; host_addr = 4'd13; host_wdata = 16'h0015; cfg_sel = 3'd4;
        @(negedge clk);
        host_we = 1'b0; cfg_sel = '0;
        rd(4'd8, v);  chk("R8 pop while full", v, 16'h0010);
        chk("R8 still full after push+pop", {15'h0, f0_full}, 16'h0001);
        rd(4'd14, v); chk("R8 no error on push+pop", v, 16'h0001);
        run(3'd4, 3);
        chk("R8 F1 full", {15'h0, f1_full}, 16'h0001);
        run(3'd4, 1);
        rd(4'd8, v);  chk("R8 order keeps late byte last", v, 16'h0015);
        rd(4'd14, v); chk("R9 F1 overflow bit", v, 16'h0005);
        run(3'd4, 1);
        rd(4'd8, v);  chk("R6 empty F0 operand zero", v, 16'h0000);
        chk("R11 zero after empty pop", {15'h0, zero_flag}, 16'h0001);
        rd(4'd14, v); chk("R9 F0 underflow bit", v, 16'h0007);
        rd(4'd13, v); chk("R8 F1 head order", v, 16'h0010);
        pop1(); pop1(); pop1();
        rd(4'd13, v); chk("R9 F1 kept after overflow", v, 16'h0013);
        pop1();
        pop1();
        rd(4'd14, v); chk("R9 F1 underflow bit", v, 16'h000F);
        rd(4'd13, v); chk("R7 empty F1 reads zero", v, 16'h0000);
        hw(4'd14, 16'h0005);
        rd(4'd14, v); chk("R9 partial clear", v, 16'h000A);
        hw(4'd14, 16'h000A);
        rd(4'd14, v); chk("R9 full clear", v, 16'h0000);

        // R12: reset mid-run clears state again.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(4'd4, v);  chk("R12 R1 cfg cleared", v, 16'h0000);
        rd(4'd9, v);  chk("R12 A1 cleared", v, 16'h0000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule